// File: doc/BRIEF.md
# Packed Narrowing Conversion Unit

This unit narrows a vector of up to eight packed 64-bit integer lanes into 32-bit lanes. Each request chooses one of three conversions: keep the low half of each lane, clamp the lane as a signed value, or clamp it as an unsigned value. The packed results fill the destination from the least-significant 32-bit lane upward. A length code selects 2, 4 or 8 active lanes, which corresponds to a source vector of 128, 256 or 512 bits.

A per-lane mask decides which result lanes are written. When masking is off, every active lane is written. Lanes that are not selected either keep the old destination value or are cleared. A destination-kind flag picks one of two behaviours. A register destination clears all bits above the packed result, up to 512 bits. A store destination raises byte enables only for written lanes and touches nothing above the stored width. Requests arrive on a valid/ready interface and carry the source vector, the old destination contents, the mask and the control fields. One cycle after acceptance the unit presents a registered result, byte enables and an illegal-encoding flag.

Top module: `narrow_pack_unit`

## Requirements
- R1: `req_ready` is high whenever `out_valid` is low or `out_ready` is high. An accepted request appears with `out_valid` high in the next cycle. A result that is taken with no new request leaves `out_valid` low in the following cycle.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_be` and `out_illegal` hold their values.
- R3: When `rst_n` is low at a rising clock edge, `out_valid`, `out_data`, `out_be` and `out_illegal` are cleared. The reset is synchronous.
- R4: `req_len` 0, 1 and 2 select 2, 4 and 8 active lanes. Result lane j is taken from `req_src[64j+63:64j]` and placed in `out_data[32j+31:32j]`.
- R5: Mode code 8'h35 truncates: the result is bits [31:0] of the lane.
- R6: Mode code 8'h25 saturates as signed: values above 32'h7FFFFFFF give 32'h7FFFFFFF, values below -2^31 give 32'h80000000, and all other values keep their low 32 bits.
- R7: Mode code 8'h15 saturates as unsigned: any lane with a nonzero upper half gives 32'hFFFFFFFF. Otherwise the low 32 bits are kept.
- R8: With `req_mask_en`=1, active lane j is written only if `req_mask[j]` is 1. An unselected register lane takes `req_old[32j+31:32j]` when `req_zero`=0 and zero when `req_zero`=1. With `req_mask_en`=0, `req_mask` is ignored and every active lane is written.
- R9: For a register destination (`req_store`=0), `out_data` is zero from bit 32×lanes up to bit 511, and `out_be` is all zero.
- R10: For a store destination (`req_store`=1), `out_be[4j+3:4j]` is 4'hF for each active lane that is written and 4'h0 for every other lane. An unselected active lane carries its old value with its enables low. Data above the stored width is zero.
- R11: `out_illegal` is 1 when any of these holds: `req_rsvd` differs from 4'b1111, a store is requested with `req_zero`=1, the mode code is not one of the three codes, or `req_len`=3. An illegal result has `out_data` and `out_be` all zero. For a legal request `out_illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_src | input | 512 | Source vector of 64-bit lanes |
| req_old | input | 256 | Old destination contents, used for merging |
| req_mask | input | 8 | Per-lane write mask |
| req_mask_en | input | 1 | Masking enabled |
| req_zero | input | 1 | Clear unselected lanes instead of merging |
| req_mode | input | 8 | Conversion code: 8'h35, 8'h25 or 8'h15 |
| req_len | input | 2 | Lane-count code: 0, 1 or 2 selects 2, 4 or 8 lanes |
| req_store | input | 1 | Destination is a store, not a register |
| req_rsvd | input | 4 | Reserved field; must be 4'b1111 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 512 | Packed result with cleared upper bits |
| out_be | output | 32 | Byte enables for a store |
| out_illegal | output | 1 | Illegal encoding; write suppressed |

## Verification
Two things can happen in the same cycle: the pending result is handed off and a new request is accepted. The bench holds `out_ready` low while a second request waits at the input, and checks that the first result stays unchanged and that `req_ready` stays low. It then raises `out_ready` with the second request still present, so that one edge both drains the first result and captures the second. The bench then checks that `out_valid` stays high and that the data changes to the second request's expected value with no gap cycle.

// File: rtl/narrow_pkg.sv
// Shared constants and types for the packed narrowing unit.
// Assumes source lanes twice as wide as result lanes.
package narrow_pkg;

    localparam int unsigned WIDE_W   = 64;
    localparam int unsigned NARROW_W = 32;
    localparam int unsigned CODE_W   = 8;
    localparam int unsigned RSVD_W   = 4;

    localparam logic [CODE_W-1:0] CODE_TRUNC = 8'h35;
    localparam logic [CODE_W-1:0] CODE_SSAT  = 8'h25;
    localparam logic [CODE_W-1:0] CODE_USAT  = 8'h15;
    localparam logic [RSVD_W-1:0] RSVD_OK    = 4'b1111;

    typedef enum logic [1:0] {
        CV_TRUNC = 2'd0,
        CV_SSAT  = 2'd1,
        CV_USAT  = 2'd2
    } conv_kind_e;

endpackage

// File: rtl/narrow_decode.sv
// Decodes the request control fields: conversion kind, active and selected
// lanes, and the illegal-encoding condition.
// Assumes LANES is a power of two and at least 2.
module narrow_decode
    import narrow_pkg::*;
#(
    parameter int unsigned LANES = 8,
    parameter int unsigned LEN_W = 2
) (
    input  logic [CODE_W-1:0] mode,
    input  logic [LEN_W-1:0]  len,
    input  logic [RSVD_W-1:0] rsvd,
    input  logic              store,
    input  logic              zero,
    input  logic              mask_en,
    input  logic [LANES-1:0]  mask,
    output conv_kind_e        kind,
    output logic [LANES-1:0]  lane_act,
    output logic [LANES-1:0]  lane_sel,
    output logic              illegal
);

    logic mode_ok;
    logic len_ok;

    // Map the conversion code onto an internal kind.
    always_comb begin
        mode_ok = 1'b1;
        kind    = CV_TRUNC;
        case (mode)
            CODE_TRUNC: kind = CV_TRUNC;
            CODE_SSAT:  kind = CV_SSAT;
            CODE_USAT:  kind = CV_USAT;
            default:    mode_ok = 1'b0;
        endcase
    end

    // Work out which lanes the length code makes active.
    always_comb begin
        int unsigned cnt;
        cnt    = 32'd2 << len;
        len_ok = (cnt <= LANES);
        for (int j = 0; j < LANES; j++) begin
            lane_act[j] = (j < cnt);
        end
    end

    // A lane is selected when active and either unmasked or its mask bit is set.
    always_comb begin
        lane_sel = lane_act & (mask_en ? mask : {LANES{1'b1}});
    end

    // Any bad field makes the whole request illegal.
    always_comb begin
        illegal = !mode_ok || !len_ok || (rsvd != RSVD_OK) || (store && zero);
    end

endmodule

// File: rtl/narrow_lane.sv
// One result lane: converts a wide lane to a narrow one and applies the
// mask, merge/zero choice and store byte enables.
// Assumes WIDE_W > NARROW_W and NARROW_W a multiple of 8.
module narrow_lane
    import narrow_pkg::*;
#(
    parameter int unsigned W_IN  = WIDE_W,
    parameter int unsigned W_OUT = NARROW_W
) (
    input  logic [W_IN-1:0]       src,
    input  logic [W_OUT-1:0]      old,
    input  conv_kind_e            kind,
    input  logic                  active,
    input  logic                  sel,
    input  logic                  zero,
    input  logic                  store,
    input  logic                  illegal,
    output logic [W_OUT-1:0]      data,
    output logic [W_OUT/8-1:0]    be
);

    localparam int unsigned BYTES = W_OUT / 8;
    localparam logic [W_OUT-1:0] S_MAX = {1'b0, {(W_OUT-1){1'b1}}};
    localparam logic [W_OUT-1:0] S_MIN = {1'b1, {(W_OUT-1){1'b0}}};
    localparam logic [W_OUT-1:0] U_MAX = {W_OUT{1'b1}};

    logic [W_OUT-1:0] conv;
    logic             s_fits;
    logic             u_over;

    // Range checks for the two saturating conversions.
    always_comb begin
        s_fits = (&src[W_IN-1:W_OUT-1]) || !(|src[W_IN-1:W_OUT-1]);
        u_over = |src[W_IN-1:W_OUT];
    end

    // Pick the converted value for the requested kind.
    always_comb begin
        case (kind)
            CV_SSAT: conv = s_fits ? src[W_OUT-1:0] : (src[W_IN-1] ? S_MIN : S_MAX);
            CV_USAT: conv = u_over ? U_MAX : src[W_OUT-1:0];
            default: conv = src[W_OUT-1:0];
        endcase
    end

    // Resolve the lane value from legality, activity, mask and merge mode.
    always_comb begin
        if (illegal || !active) begin
            data = '0;
        end else if (sel) begin
            data = conv;
        end else if (zero && !store) begin
            data = '0;
        end else begin
            data = old;
        end
    end

    // Byte enables only for written lanes of a legal store.
    always_comb begin
        be = (!illegal && active && sel && store) ? {BYTES{1'b1}} : {BYTES{1'b0}};
    end

endmodule

// File: rtl/narrow_pack_unit.sv
// Packed narrowing conversion unit. Takes one request per cycle on a
// valid/ready interface and presents a registered result one cycle later.
// Assumes the consumer holds out_ready stable within a cycle; reset is
// synchronous and active low.
module narrow_pack_unit
    import narrow_pkg::*;
#(
    parameter int unsigned LANES = 8,
    parameter int unsigned LEN_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [LANES*WIDE_W-1:0]   req_src,
    input  logic [LANES*NARROW_W-1:0] req_old,
    input  logic [LANES-1:0]          req_mask,
    input  logic                      req_mask_en,
    input  logic                      req_zero,
    input  logic [CODE_W-1:0]         req_mode,
    input  logic [LEN_W-1:0]          req_len,
    input  logic                      req_store,
    input  logic [RSVD_W-1:0]         req_rsvd,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [LANES*WIDE_W-1:0]   out_data,
    output logic [LANES*NARROW_W/8-1:0] out_be,
    output logic                      out_illegal
);

    localparam int unsigned SRC_W  = LANES * WIDE_W;
    localparam int unsigned PACK_W = LANES * NARROW_W;
    localparam int unsigned LBE    = NARROW_W / 8;
    localparam int unsigned BE_W   = LANES * LBE;

    conv_kind_e         kind;
    logic [LANES-1:0]   lane_act;
    logic [LANES-1:0]   lane_sel;
    logic               illegal;
    logic [PACK_W-1:0]  pack_d;
    logic [BE_W-1:0]    be_d;
    logic               accept;

    logic               valid_q;
    logic [PACK_W-1:0]  data_q;
    logic [BE_W-1:0]    be_q;
    logic               ill_q;

    narrow_decode #(
        .LANES (LANES),
        .LEN_W (LEN_W)
    ) u_decode (
        .mode     (req_mode),
        .len      (req_len),
        .rsvd     (req_rsvd),
        .store    (req_store),
        .zero     (req_zero),
        .mask_en  (req_mask_en),
        .mask     (req_mask),
        .kind     (kind),
        .lane_act (lane_act),
        .lane_sel (lane_sel),
        .illegal  (illegal)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        narrow_lane #(
            .W_IN  (WIDE_W),
            .W_OUT (NARROW_W)
        ) u_lane (
            .src     (req_src[j*WIDE_W +: WIDE_W]),
            .old     (req_old[j*NARROW_W +: NARROW_W]),
            .kind    (kind),
            .active  (lane_act[j]),
            .sel     (lane_sel[j]),
            .zero    (req_zero),
            .store   (req_store),
            .illegal (illegal),
            .data    (pack_d[j*NARROW_W +: NARROW_W]),
            .be      (be_d[j*LBE +: LBE])
        );
    end

    // Accept when the output stage is empty or being drained.
    always_comb begin
        req_ready = !valid_q || out_ready;
        accept    = req_valid && req_ready;
    end

    // Output stage: capture on accept, clear valid once taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
            be_q    <= '0;
            ill_q   <= 1'b0;
        end else if (accept) begin
            valid_q <= 1'b1;
            data_q  <= pack_d;
            be_q    <= be_d;
            ill_q   <= illegal;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    // Drive outputs; bits above the packed width are always clear.
    always_comb begin
        out_valid   = valid_q;
        out_data    = {{(SRC_W-PACK_W){1'b0}}, data_q};
        out_be      = be_q;
        out_illegal = ill_q;
    end

endmodule

// File: rtl/narrow_pack_unit_chk.sv
// Property checker for narrow_pack_unit, attached through bind.
// Observes ports only; assumes the default lane count of the top.
module narrow_pack_unit_chk
    import narrow_pkg::*;
#(
    parameter int unsigned LANES = 8,
    parameter int unsigned LEN_W = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_ready,
    input logic                        req_zero,
    input logic [LEN_W-1:0]            req_len,
    input logic                        req_store,
    input logic [RSVD_W-1:0]           req_rsvd,
    input logic                        out_valid,
    input logic                        out_ready,
    input logic [LANES*WIDE_W-1:0]     out_data,
    input logic [LANES*NARROW_W/8-1:0] out_be,
    input logic                        out_illegal
);

    localparam int unsigned SRC_W = LANES * WIDE_W;
    localparam int unsigned BE_W  = LANES * NARROW_W / 8;
    localparam int unsigned LBE   = NARROW_W / 8;

    logic accept;
    assign accept = req_valid && req_ready;

    // R1
    accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    // R1
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !req_valid) |=> !out_valid);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
            && $stable(out_be) && $stable(out_illegal)));

    // R9
    reg_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_store && req_len == '0) |=>
            (out_data[SRC_W-1:2*NARROW_W] == '0 && out_be == '0));

    // R10
    store_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_store && req_len == '0) |=>
            (out_be[BE_W-1:2*LBE] == '0 && out_data[SRC_W-1:2*NARROW_W] == '0));

    // R11
    rsvd_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_rsvd != RSVD_OK) |=>
            (out_illegal && out_be == '0 && out_data == '0));

    // R11
    store_zero_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_store && req_zero) |=> out_illegal);

endmodule

bind narrow_pack_unit narrow_pack_unit_chk #(
    .LANES (LANES),
    .LEN_W (LEN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_zero    (req_zero),
    .req_len     (req_len),
    .req_store   (req_store),
    .req_rsvd    (req_rsvd),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_be      (out_be),
    .out_illegal (out_illegal)
);

// File: tb/narrow_pack_unit_bench.sv
// Bench for narrow_pack_unit: a vector table walked by one loop, then
// directed reset, back-pressure and back-to-back tests.
module narrow_pack_unit_bench;

    typedef struct packed {
        logic [63:0] base;
        logic [63:0] step;
        logic [7:0]  mask;
        logic        men;
        logic        zro;
        logic [7:0]  mode;
        logic [1:0]  len;
        logic        st;
        logic [3:0]  rsv;
        logic        ill;
        logic [31:0] lane0;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [0:NV-1] = '{
        '{64'h1234_5678_9ABC_DEF0, 64'h0000_0001_0000_0001, 8'hFF, 1'b0, 1'b0, 8'h35, 2'd2, 1'b0, 4'hF, 1'b0, 32'h9ABC_DEF0},
        '{64'h0000_0001_0000_0000, 64'hFFFF_FFFF_8000_0000, 8'hFF, 1'b0, 1'b0, 8'h25, 2'd2, 1'b0, 4'hF, 1'b0, 32'h7FFF_FFFF},
        '{64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b0, 1'b0, 8'h25, 2'd1, 1'b0, 4'hF, 1'b0, 32'h8000_0000},
        '{64'h0000_0000_7FFF_FFFF, 64'h0000_0000_0000_0001, 8'hFF, 1'b0, 1'b0, 8'h25, 2'd0, 1'b0, 4'hF, 1'b0, 32'h7FFF_FFFF},
        '{64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 8'hFF, 1'b0, 1'b0, 8'h15, 2'd2, 1'b0, 4'hF, 1'b0, 32'hFFFF_FFFF},
        '{64'h8000_0000_0000_0005, 64'h0000_0000_0000_0000, 8'hFF, 1'b0, 1'b0, 8'h15, 2'd1, 1'b0, 4'hF, 1'b0, 32'hFFFF_FFFF},
        '{64'h0000_0000_0000_0005, 64'h0000_0000_0000_0003, 8'hFF, 1'b0, 1'b0, 8'h15, 2'd2, 1'b0, 4'hF, 1'b0, 32'h0000_0005},
        '{64'hDEAD_BEEF_0000_0011, 64'h0000_0100_0000_0100, 8'hA5, 1'b1, 1'b0, 8'h35, 2'd2, 1'b0, 4'hF, 1'b0, 32'h0000_0011},
        '{64'hDEAD_BEEF_0000_0011, 64'h0000_0100_0000_0100, 8'h5A, 1'b1, 1'b1, 8'h35, 2'd2, 1'b0, 4'hF, 1'b0, 32'h0000_0000},
        '{64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_4000_0000, 8'h00, 1'b0, 1'b1, 8'h25, 2'd2, 1'b0, 4'hF, 1'b0, 32'hFFFF_FFF0},
        '{64'h1111_2222_3333_4444, 64'h0000_0000_0000_0010, 8'h06, 1'b1, 1'b0, 8'h35, 2'd1, 1'b1, 4'hF, 1'b0, 32'hA0A0_0A00},
        '{64'h0000_0002_0000_0000, 64'h0000_0000_0000_0001, 8'h00, 1'b0, 1'b0, 8'h15, 2'd0, 1'b1, 4'hF, 1'b0, 32'hFFFF_FFFF},
        '{64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 8'hFF, 1'b0, 1'b0, 8'h35, 2'd2, 1'b0, 4'hE, 1'b1, 32'h0000_0000},
        '{64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 8'hFF, 1'b1, 1'b1, 8'h35, 2'd2, 1'b1, 4'hF, 1'b1, 32'h0000_0000},
        '{64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 8'hFF, 1'b0, 1'b0, 8'h45, 2'd2, 1'b0, 4'hF, 1'b1, 32'h0000_0000},
        '{64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 8'hFF, 1'b0, 1'b0, 8'h35, 2'd3, 1'b0, 4'hF, 1'b1, 32'h0000_0000},
        '{64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000, 8'hFF, 1'b0, 1'b0, 8'h25, 2'd0, 1'b0, 4'hF, 1'b0, 32'h8000_0000}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [511:0] req_src = '0;
    logic [255:0] req_old = '0;
    logic [7:0]   req_mask = '0;
    logic         req_mask_en = 1'b0;
    logic         req_zero = 1'b0;
    logic [7:0]   req_mode = 8'h35;
    logic [1:0]   req_len = 2'd0;
    logic         req_store = 1'b0;
    logic [3:0]   req_rsvd = 4'hF;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [511:0] out_data;
    logic [31:0]  out_be;
    logic         out_illegal;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    narrow_pack_unit u_narrow_pack_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_src     (req_src),
        .req_old     (req_old),
        .req_mask    (req_mask),
        .req_mask_en (req_mask_en),
        .req_zero    (req_zero),
        .req_mode    (req_mode),
        .req_len     (req_len),
        .req_store   (req_store),
        .req_rsvd    (req_rsvd),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_be      (out_be),
        .out_illegal (out_illegal)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected result from the requirement text (R4 to R11).
    task automatic model(output logic [511:0] d, output logic [31:0] be,
                         output logic ill);
        int unsigned lanes;
        lanes = 32'd2 << req_len;
        ill = (req_rsvd != 4'hF) || (req_store && req_zero) || (req_len == 2'd3)
              || !(req_mode == 8'h35 || req_mode == 8'h25 || req_mode == 8'h15);
        d  = '0;
        be = '0;
        if (!ill) begin
            for (int j = 0; j < int'(lanes); j++) begin
                logic [63:0] s;
                logic [31:0] c;
                s = req_src[j*64 +: 64];
                if (req_mode == 8'h25) begin
                    if ($signed(s) > 64'sh7FFF_FFFF)       c = 32'h7FFF_FFFF;
                    else if ($signed(s) < -64'sh8000_0000) c = 32'h8000_0000;
                    else                                   c = s[31:0];
                end else if (req_mode == 8'h15) begin
                    c = (s > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : s[31:0];
                end else begin
                    c = s[31:0];
                end
                if (!req_mask_en || req_mask[j]) begin
                    d[j*32 +: 32] = c;
                    if (req_store) be[j*4 +: 4] = 4'hF;
                end else if (!req_store && req_zero) begin
                    d[j*32 +: 32] = '0;
                end else begin
                    d[j*32 +: 32] = req_old[j*32 +: 32];
                end
            end
        end
    endtask

    task automatic load(input vec_t v, input int k);
        req_mask    = v.mask;
        req_mask_en = v.men;
        req_zero    = v.zro;
        req_mode    = v.mode;
        req_len     = v.len;
        req_store   = v.st;
        req_rsvd    = v.rsv;
        for (int j = 0; j < 8; j++) begin
            req_src[j*64 +: 64] = v.base + 64'(j) * v.step;
            req_old[j*32 +: 32] = {16'hA0A0, 8'(k), 8'(j)};
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.ill)        return "R11";
        if (v.st)         return "R10";
        if (v.men)        return "R8";
        if (v.mode == 8'h25) return "R6";
        if (v.mode == 8'h15) return "R7";
        return "R5";
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [511:0] ed;
        logic [31:0]  eb;
        logic         ei;
        logic [511:0] first_d;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R3: reset state
        check(out_valid == 1'b0, "R3 valid after reset", 512'(out_valid), 512'd0);
        check(out_data == '0 && out_be == '0 && !out_illegal, "R3 outputs after reset",
              out_data, 512'd0);
        check(req_ready == 1'b1, "R1 ready when empty", 512'(req_ready), 512'd1);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            load(VECS[k], k);
            model(ed, eb, ei);
            req_valid = 1'b1;
            out_ready = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check(out_valid == 1'b1, "R1 valid after accept", 512'(out_valid), 512'd1);
            check(out_illegal == VECS[k].ill, "R11 illegal flag",
                  512'(out_illegal), 512'(VECS[k].ill));
            check(out_data[31:0] == VECS[k].lane0, tag_of(VECS[k]),
                  512'(out_data[31:0]), 512'(VECS[k].lane0));
            check(out_data == ed, "R4/R9 full result", out_data, ed);
            check(out_be == eb, "R10 byte enables", 512'(out_be), 512'(eb));
            @(negedge clk);
            check(out_valid == 1'b0, "R1 valid drops after take", 512'(out_valid), 512'd0);
        end

        // R2 and R1: back-pressure, then drain and accept on one edge
        @(negedge clk);
        load(VECS[0], 0);
        model(ed, eb, ei);
        first_d   = ed;
        req_valid = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        load(VECS[6], 6);
        for (int c = 0; c < 3; c++) begin
            check(req_ready == 1'b0, "R1 not ready when stalled", 512'(req_ready), 512'd0);
            check(out_valid && out_data == first_d, "R2 hold under back-pressure",
                  out_data, first_d);
            @(negedge clk);
        end
        model(ed, eb, ei);
        out_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(out_valid == 1'b1, "R1 back-to-back valid", 512'(out_valid), 512'd1);
        check(out_data == ed, "R1 back-to-back data", out_data, ed);
        @(negedge clk);

        // R3: synchronous reset mid-run clears the held result
        load(VECS[4], 4);
        req_valid = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check(out_valid == 1'b1, "R3 pre-reset valid", 512'(out_valid), 512'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_data == '0, "R3 reset clears result",
              out_data, 512'd0);
        rst_n = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule